// File: doc/BRIEF.md
# Counted Edge Burst Generator

The block drives one output pin and toggles it a programmed number of times, with consecutive edges spaced by a programmable interval measured in clock cycles. An internal timebase counts that interval repeatedly while the block is enabled. Every time the timebase wraps, one edge is produced, provided edges remain in the current burst. Software loads the interval through a period write port and starts a burst by writing an edge count.

A count written while a burst is still running replaces what is left of the old one. Because the timebase keeps running across the replacement, the new burst continues on the same edge grid with no gap and no short interval. A period write is held as pending and takes effect only when the current interval ends. When the enable input is low, the block is held in reset: the timebase stops, the remaining count is cleared, and the pin keeps its level. When enable rises, the timebase restarts from zero. A count written in that same cycle gives its first edge one full interval later. Several instances that share one enable therefore stay in phase.

Top module: `edge_burst_gen`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, pin_out is 0, done is 0 and count_left is 0.
- R2: When en rises in the same cycle that a count of N>0 is written, with period P, pin_out does not change during the next P-1 cycles and changes exactly P cycles after the write.
- R3: Each further edge of a burst comes exactly P cycles after the previous one.
- R4: Each edge lowers count_left by one. When count_left reaches 0, the pin stops toggling and keeps its last level.
- R5: done goes to 1 on the same clock as the final edge of a burst. It returns to 0 on the clock of any count write, or when en is low.
- R6: With en low, count_left reads 0 from the next clock on, no edge occurs, pin_out keeps its level, and count writes are ignored. When en rises again, the timebase restarts from zero.
- R7: A count written during a running burst replaces the remaining count at once. The next edge still falls on the existing P-cycle grid.
- R8: When a count write lands on the same clock as a timebase wrap and edges are still remaining, the edge of that wrap is still produced. The new count is then loaded in full and done stays 0.
- R9: A period write takes effect at the next timebase wrap. The interval in progress finishes with the old period, and the following intervals use the new one.
- R10: A period value of 0 gives an interval of 65536 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low holds the block in reset |
| per_wr | input | 1 | Period write strobe |
| per_data | input | PER_W (16) | Interval between edges in clocks, 0 means 65536 |
| cnt_wr | input | 1 | Edge count write strobe, accepted only while en is high |
| cnt_data | input | CNT_W (16) | Number of edges to produce |
| pin_out | output | 1 | Toggling output pin |
| done | output | 1 | High after the final edge of a burst |
| count_left | output | CNT_W (16) | Edges still to be produced |

## Verification
The two functions that can fall in the same cycle are a software count write and a timebase wrap that carries an edge of the running burst. The bench provokes this by timing a count write so that it is captured exactly on the wrap that would otherwise give the last edge of a two-edge burst. The expected result is that the edge still appears, done stays low, count_left shows the whole new count, and the following edges continue on the original grid. A second collision is a period write made in the middle of an interval; the bench judges it by the spacing of the edges on either side of the next wrap.

// File: rtl/ebg_pkg.sv
// Package: shared defaults for the counted edge burst generator.
// Assumes: all blocks of the generator import these widths as defaults.
package ebg_pkg;
    localparam int unsigned PER_W_DEF = 16;   // width of the interval register
    localparam int unsigned CNT_W_DEF = 16;   // width of the edge counter
endpackage

// File: rtl/ebg_timebase.sv
// Module: ebg_timebase
// Counts the edge interval while the generator is enabled and emits a
// one-cycle wrap strobe at the end of every interval. The written period
// is held as pending and is copied into the active period at a wrap, or at
// any time while the timebase is stopped.
// Assumes: en is synchronous to clk. A period value of 0 means 2**PER_W clocks.
module ebg_timebase #(
    parameter int unsigned PER_W = ebg_pkg::PER_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             per_wr,
    input  logic [PER_W-1:0] per_data,
    output logic             wrap
);
    logic [PER_W-1:0] per_pend;
    logic [PER_W-1:0] per_act;
    logic [PER_W-1:0] tick;
    logic [PER_W-1:0] tick_last;
    logic             running;

    // Last tick value of an interval; wrapping makes 0 the largest period.
    assign tick_last = per_act - 1'b1;

    // Interval ends when the running count reaches its last tick.
    assign wrap = en && running && (tick == tick_last);

    // Running flag: one cycle behind en, so a rising en starts at tick zero.
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else        running <= en;
    end

    // Pending period register, written by software at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)      per_pend <= '0;
        else if (per_wr) per_pend <= per_data;
    end

    // Active period: loaded at a wrap or while the timebase is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                per_act <= '0;
        else if (!running || wrap) per_act <= per_pend;
    end

    // Tick counter: held at zero while stopped, wraps at the end of an interval.
    always_ff @(posedge clk) begin
        if (!rst_n)               tick <= '0;
        else if (!en || !running) tick <= '0;
        else if (tick == tick_last) tick <= '0;
        else                      tick <= tick + 1'b1;
    end
endmodule

// File: rtl/ebg_segment.sv
// Module: ebg_segment
// Keeps the number of edges left in the current burst. It asks for an edge
// on every timebase wrap while edges remain, and flags the final one.
// A count write replaces the remaining count and clears the flag.
// Assumes: wrap is a single-cycle strobe. Writes are ignored while en is low.
module ebg_segment #(
    parameter int unsigned CNT_W = ebg_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wrap,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_data,
    output logic             toggle,
    output logic             done,
    output logic [CNT_W-1:0] remaining
);
    logic has_edges;
    logic is_final;

    assign has_edges = (remaining != '0);
    assign is_final  = (remaining == CNT_W'(1));

    // Edge request: a wrap while the burst still has edges left.
    assign toggle = en && wrap && has_edges;

    // Remaining count and done flag; a write takes priority over a decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            done      <= 1'b0;
        end else if (!en) begin
            remaining <= '0;
            done      <= 1'b0;
        end else if (cnt_wr) begin
            remaining <= cnt_data;
            done      <= 1'b0;
        end else if (toggle) begin
            remaining <= remaining - 1'b1;
            if (is_final) done <= 1'b1;
        end
    end
endmodule

// File: rtl/ebg_pin.sv
// Module: ebg_pin
// Output pin register: inverts the level on each edge request and keeps it
// otherwise, so the level carries over from one burst to the next.
// Assumes: flip is a single-cycle request. The pin resets low.
module ebg_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic level
);
    // Pin level: reset low, inverted on each request.
    always_ff @(posedge clk) begin
        if (!rst_n)    level <= 1'b0;
        else if (flip) level <= ~level;
    end
endmodule

// File: rtl/edge_burst_gen.sv
// Module: edge_burst_gen (top)
// Counted edge burst generator: toggles pin_out a written number of times,
// with one edge per period of a running timebase. A count written during a
// burst joins onto the current edge grid without a gap.
// Assumes: every input is synchronous to clk. en low acts as a soft reset
// that keeps the pin level.
module edge_burst_gen #(
    parameter int unsigned PER_W = ebg_pkg::PER_W_DEF,
    parameter int unsigned CNT_W = ebg_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             per_wr,
    input  logic [PER_W-1:0] per_data,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_data,
    output logic             pin_out,
    output logic             done,
    output logic [CNT_W-1:0] count_left
);
    logic wrap;
    logic toggle;

    // Interval timebase with a pending period register.
    ebg_timebase #(.PER_W(PER_W)) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .per_wr   (per_wr),
        .per_data (per_data),
        .wrap     (wrap)
    );

    // Burst counter and done flag.
    ebg_segment #(.CNT_W(CNT_W)) u_segment (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .wrap      (wrap),
        .cnt_wr    (cnt_wr),
        .cnt_data  (cnt_data),
        .toggle    (toggle),
        .done      (done),
        .remaining (count_left)
    );

    // Output pin register.
    ebg_pin u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  (toggle),
        .level (pin_out)
    );
endmodule

// File: rtl/edge_burst_gen_chk.sv
// Module: edge_burst_gen_chk
// Property checker for the edge burst generator, bound to the top module.
// Assumes: it only observes the top ports and drives nothing.
module edge_burst_gen_chk #(
    parameter int unsigned CNT_W = ebg_pkg::CNT_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             cnt_wr,
    input logic             pin_out,
    input logic             done,
    input logic [CNT_W-1:0] count_left
);
    // R1: reset leaves the pin low, done low and the count empty.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!pin_out && !done && count_left == '0));

    // R4: an edge needs a non-empty count while enabled.
    assert_edge_needs_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out != $past(pin_out)) |-> ($past(count_left) != '0 && $past(en)));

    // R4: an edge without a coincident write lowers the count by one.
    assert_edge_decrements_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out != $past(pin_out)) && !$past(cnt_wr))
            |-> (count_left == CNT_W'($past(count_left) - 1'b1)));

    // R5: done only rises together with an edge.
    assert_done_with_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (pin_out != $past(pin_out)));

    // R5: done implies an empty count.
    assert_done_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count_left == '0));

    // R6: enable low clears the count on the next clock.
    assert_idle_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count_left == '0 && !done));
endmodule

bind edge_burst_gen edge_burst_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cnt_wr     (cnt_wr),
    .pin_out    (pin_out),
    .done       (done),
    .count_left (count_left)
);

// File: tb/test_edge_burst_gen.sv
// Directed bench for edge_burst_gen: one task per scenario, each checks its
// own results against edge times worked out from the requirements.
module test_edge_burst_gen;
    localparam int PER_W = 16;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             per_wr = 1'b0;
    logic [PER_W-1:0] per_data = '0;
    logic             cnt_wr = 1'b0;
    logic [CNT_W-1:0] cnt_data = '0;
    logic             pin_out;
    logic             done;
    logic [CNT_W-1:0] count_left;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_edges = 0;
    int edge_at [0:63];
    logic pin_prev = 1'b0;

    edge_burst_gen #(.PER_W(PER_W), .CNT_W(CNT_W)) i_edge_burst_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .per_wr     (per_wr),
        .per_data   (per_data),
        .cnt_wr     (cnt_wr),
        .cnt_data   (cnt_data),
        .pin_out    (pin_out),
        .done       (done),
        .count_left (count_left)
    );

    // 125 MHz clock
    always #4 clk = ~clk;

    // Index of the most recent rising edge
    always @(posedge clk) cyc <= cyc + 1;

    // Edge log: record the clock index at which the pin changed
    always @(posedge clk) begin
        #2;
        if (pin_out !== pin_prev) begin
            if (n_edges < 64) edge_at[n_edges] = cyc;
            n_edges = n_edges + 1;
        end
        pin_prev = pin_out;
    end

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic check_edge(input string req, input int idx, input int exp);
        int act;
        act = (n_edges > idx) ? edge_at[idx] : -1;
        check(req, act == exp, act, exp);
    endtask

    // Write a count so that it is captured on rising edge c
    task automatic write_cnt_at(input int c, input int val);
        wait_until(c - 1);
        cnt_wr = 1'b1;
        cnt_data = CNT_W'(val);
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    // Write a period so that it is captured on rising edge c
    task automatic write_per_at(input int c, input int val);
        wait_until(c - 1);
        per_wr = 1'b1;
        per_data = PER_W'(val);
        @(negedge clk);
        per_wr = 1'b0;
    endtask

    // Stop, load the period, then raise en together with a count write
    task automatic start(input int per, input int cnt, output int w);
        @(negedge clk);
        en = 1'b0;
        per_wr = 1'b1;
        per_data = PER_W'(per);
        @(negedge clk);
        per_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        n_edges = 0;
        en = 1'b1;
        cnt_wr = 1'b1;
        cnt_data = CNT_W'(cnt);
        w = cyc + 1;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pin", pin_out == 1'b0, pin_out, 0);
        check("R1 done", done == 1'b0, done, 0);
        check("R1 count", count_left == '0, count_left, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", pin_out == 1'b0 && count_left == '0, count_left, 0);
    endtask

    task automatic t_basic;
        int w;
        int c;
        logic lvl;
        lvl = pin_out;
        start(5, 3, w);
        wait_until(w + 4);
        check("R2 no early edge", pin_out == lvl, pin_out, lvl);
        check("R2 count loaded", count_left == 16'd3, count_left, 3);
        wait_until(w + 5);
        check("R2 first edge", pin_out == !lvl, pin_out, !lvl);
        check("R4 decrement", count_left == 16'd2, count_left, 2);
        wait_until(w + 14);
        check("R5 done not early", done == 1'b0, done, 0);
        wait_until(w + 15);
        check("R5 done with final edge", done == 1'b1, done, 1);
        wait_until(w + 20);
        check("R3 edge count", n_edges == 3, n_edges, 3);
        check_edge("R3 second edge", 1, w + 10);
        check_edge("R3 third edge", 2, w + 15);
        check("R4 empty", count_left == '0, count_left, 0);
        c = cyc + 1;
        write_cnt_at(c, 0);
        wait_until(c);
        check("R5 cleared by write", done == 1'b0, done, 0);
        wait_until(c + 12);
        check("R4 stopped at zero", n_edges == 3, n_edges, 3);
        check("R4 level kept", pin_out == !lvl, pin_out, !lvl);
    endtask

    task automatic t_chain;
        int w;
        start(4, 3, w);
        write_cnt_at(w + 6, 2);
        wait_until(w + 7);
        check("R7 count replaced", count_left == 16'd2, count_left, 2);
        wait_until(w + 24);
        check("R7 total edges", n_edges == 3, n_edges, 3);
        check_edge("R7 edge before write", 0, w + 4);
        check_edge("R7 edge on grid", 1, w + 8);
        check_edge("R7 last edge", 2, w + 12);
        check("R7 done", done == 1'b1, done, 1);
    endtask

    task automatic t_coincide;
        int w;
        start(4, 2, w);
        write_cnt_at(w + 8, 2);
        wait_until(w + 8);
        check("R8 edge kept on write", n_edges == 2, n_edges, 2);
        check("R8 done held low", done == 1'b0, done, 0);
        check("R8 full count", count_left == 16'd2, count_left, 2);
        wait_until(w + 24);
        check("R8 total edges", n_edges == 4, n_edges, 4);
        check_edge("R8 third edge", 2, w + 12);
        check_edge("R8 fourth edge", 3, w + 16);
        check("R8 done at end", done == 1'b1, done, 1);
    endtask

    task automatic t_enable;
        int w;
        int w2;
        logic lvl;
        start(3, 10, w);
        wait_until(w + 6);
        en = 1'b0;
        @(negedge clk);
        check("R6 count cleared", count_left == '0, count_left, 0);
        lvl = pin_out;
        write_cnt_at(w + 9, 5);
        wait_until(w + 10);
        check("R6 write ignored", count_left == '0, count_left, 0);
        wait_until(w + 30);
        check("R6 no edges while low", n_edges == 2, n_edges, 2);
        check("R6 level held", pin_out == lvl, pin_out, lvl);
        start(3, 1, w2);
        wait_until(w2 + 2);
        check("R6 restart no early edge", n_edges == 0, n_edges, 0);
        wait_until(w2 + 3);
        check("R6 restart edge", n_edges == 1, n_edges, 1);
    endtask

    task automatic t_period_change;
        int w;
        start(6, 4, w);
        write_per_at(w + 2, 3);
        wait_until(w + 20);
        check("R9 edges", n_edges == 4, n_edges, 4);
        check_edge("R9 old period kept", 0, w + 6);
        check_edge("R9 new period", 1, w + 9);
        check_edge("R9 new period again", 3, w + 15);
    endtask

    task automatic t_period_zero;
        int w;
        start(0, 1, w);
        wait_until(w + 65535);
        check("R10 no edge before 65536", n_edges == 0, n_edges, 0);
        wait_until(w + 65536);
        check("R10 edge at 65536", n_edges == 1, n_edges, 1);
        check_edge("R10 edge time", 0, w + 65536);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 8);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_chain();
        t_coincide();
        t_enable();
        t_period_change();
        t_period_zero();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule